// File: doc/BRIEF.md
# CSI-2 Packet Framing Byte Generator

This block produces the bytes that frame one camera-serial-interface packet around its payload. A supervisor presents a packet request (virtual channel, data type, 16-bit word count and a short/long flag). Once the request is taken, the block emits a sync leader byte, then a four-byte packet header carrying the data identifier, the word count and a Hamming ECC. For a long packet it then passes the payload bytes straight through while folding each into a running CRC-16, and appends the CRC as a two-byte footer. Every packet closes with a trail byte whose bits all copy the inverse of the most significant bit of the byte sent just before it.

The block does not drive any lane. Each output byte carries a select code that tells the supervisor which part of the packet it belongs to, so the supervisor decides where to forward it. Bytes appear one per cycle, except in the payload phase, where a byte appears only in cycles with a valid payload byte at the input.

The controller is a six-state machine: IDLE (waiting, request accepted on `req_valid`), LEAD (sync byte), HDR (four header bytes), PAY (payload pass-through), FTR (two CRC bytes) and TRL (trail byte). Transitions: IDLE to LEAD on a request; LEAD to HDR always; HDR to TRL after the fourth byte of a short packet, to FTR after the fourth byte of a long packet with zero word count, otherwise to PAY; PAY to FTR when the last counted payload byte passes; FTR to TRL after the second footer byte; TRL to IDLE always.

Top module: `csi_pkt_framer`

## Requirements
- R1: In the cycle after a request is accepted, the block emits the byte 0xB8 with select code 1 (leader).
- R2: The four cycles after the leader emit, with select code 2, in this order: the data identifier {vc[1:0], dt[5:0]}, word count bits 7:0, word count bits 15:8, then the ECC byte.
- R3: ECC bit k is the XOR of the header bits D[23:0] (D[7:0] = identifier, D[23:8] = word count) picked by the standard CSI-2 24-bit parity equations; ECC bits 7:6 are zero.
- R4: A short packet (`req_long` = 0) goes from the ECC byte straight to the trail byte: no payload and no footer appear, whatever the payload inputs do.
- R5: In a long packet, a cycle with `pay_valid` high in the payload phase emits `pay_data` unchanged with select code 3 in that same cycle; a cycle with `pay_valid` low emits nothing (`out_valid` low, select 0); exactly word-count bytes pass.
- R6: A long packet ends its payload with a two-byte footer (select code 4), low byte first, holding the CRC-16 with polynomial x^16+x^12+x^5+1, seed 0xFFFF, LSB-first shifting and no final inversion over exactly the passed payload bytes; a zero word count gives 0xFFFF.
- R7: The cycle after the last header or footer byte emits the trail byte (select code 5), whose eight bits all equal the inverse of bit 7 of the previous emitted byte.
- R8: `req_ready` is high only while idle; a request presented while busy is ignored and does not alter the packet in progress; payload inputs outside the payload phase are ignored.
- R9: After reset `req_ready` is 1 and `out_valid` is 0 with select code 0.
- R10: `out_valid` is high exactly when the select code is non-zero; the codes are 0 none, 1 leader, 2 header, 3 payload, 4 footer, 5 trail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_vc | input | 2 | Virtual channel of the request |
| req_dt | input | 6 | Data type of the request |
| req_wc | input | 16 | Word count (payload bytes for long packets) |
| req_long | input | 1 | 1 for a long packet, 0 for a short packet |
| pay_valid | input | 1 | Payload byte present |
| pay_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte present |
| out_sel | output | 3 | Packet part of the output byte |
| out_byte | output | 8 | Generated or forwarded byte |

## Verification
The assertions assume that reset is held low before the first edge and that every input is at a defined level on every clock edge after reset, since the acceptance and pass-through properties sample `req_valid`, `pay_valid` and `pay_data` directly. They do not model header or CRC content; those are left to the bench model. The stimulus drives every input on every cycle, including random junk on the payload inputs outside the payload phase and a held-high request with random fields while the block is busy, so the assumptions hold while the ignore paths are still exercised.

// File: rtl/csi_pkt_pkg.sv
package csi_pkt_pkg;

    localparam int BYTE_W = 8;
    localparam int VC_W   = 2;
    localparam int DT_W   = 6;
    localparam int WC_W   = 16;
    localparam int HDR_W  = BYTE_W + WC_W;
    localparam int ECC_W  = 6;
    localparam int CRC_W  = 16;

    localparam logic [BYTE_W-1:0] SYNC_BYTE    = 8'hB8;
    localparam logic [CRC_W-1:0]  CRC_SEED     = 16'hFFFF;
    localparam logic [CRC_W-1:0]  CRC_POLY_REF = 16'h8408;

    // parity masks over header bits, index k selects ECC bit k
    localparam logic [HDR_W-1:0] ECC_MASK [ECC_W] = '{
        24'hF12CB7,
        24'hF2555B,
        24'h749A6D,
        24'hB8E38E,
        24'hDF03F0,
        24'hEFFC00
    };

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_LEAD = 3'd1,
        SEL_HDR  = 3'd2,
        SEL_PAY  = 3'd3,
        SEL_FTR  = 3'd4,
        SEL_TRL  = 3'd5
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HDR,
        ST_PAY,
        ST_FTR,
        ST_TRL
    } st_e;

endpackage

// File: rtl/csi_ecc_gen.sv
module csi_ecc_gen
    import csi_pkt_pkg::*;
(
    input  logic [HDR_W-1:0]  hdr,
    output logic [BYTE_W-1:0] ecc
);

    genvar k;
    generate
        for (k = 0; k < ECC_W; k++) begin : g_par
            assign ecc[k] = ^(hdr & ECC_MASK[k]);
        end
        if (BYTE_W > ECC_W) begin : g_pad
            assign ecc[BYTE_W-1:ECC_W] = '0;
        end
    endgenerate

endmodule

// File: rtl/csi_crc_acc.sv
module csi_crc_acc #(
    parameter int               CRC_W  = 16,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 16'h8408,
    parameter logic [CRC_W-1:0] SEED   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);

    logic [CRC_W-1:0] nxt;

    // one byte per cycle, bit 0 of the byte enters first
    always_comb begin
        nxt = crc;
        for (int i = 0; i < DATA_W; i++) begin
            if (nxt[0] ^ din[i]) begin
                nxt = (nxt >> 1) ^ POLY;
            end else begin
                nxt = nxt >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= SEED;
        end else if (clr) begin
            crc <= SEED;
        end else if (en) begin
            crc <= nxt;
        end
    end

endmodule

// File: rtl/csi_pkt_framer.sv
module csi_pkt_framer
    import csi_pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_vc,
    input  logic [5:0]  req_dt,
    input  logic [15:0] req_wc,
    input  logic        req_long,
    input  logic        pay_valid,
    input  logic [7:0]  pay_data,
    output logic        out_valid,
    output logic [2:0]  out_sel,
    output logic [7:0]  out_byte
);

    localparam logic [WC_W-1:0] HDR_LAST = WC_W'(3);

    st_e               st, st_n;
    logic [WC_W-1:0]   cnt, cnt_n;
    logic [VC_W-1:0]   r_vc;
    logic [DT_W-1:0]   r_dt;
    logic [WC_W-1:0]   r_wc;
    logic              r_long;
    logic [BYTE_W-1:0] last_b;
    logic [BYTE_W-1:0] ident;
    logic [BYTE_W-1:0] ecc_b;
    logic [BYTE_W-1:0] hdr_b;
    logic [CRC_W-1:0]  crc;
    logic              crc_clr;
    logic              crc_en;

    assign ident = {r_vc, r_dt};

    csi_ecc_gen u_ecc (
        .hdr (HDR_W'({r_wc, ident})),
        .ecc (ecc_b)
    );

    assign crc_clr = (st == ST_HDR);
    assign crc_en  = (st == ST_PAY) && pay_valid;

    csi_crc_acc #(
        .CRC_W  (CRC_W),
        .DATA_W (BYTE_W),
        .POLY   (CRC_POLY_REF),
        .SEED   (CRC_SEED)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (pay_data),
        .crc   (crc)
    );

    always_comb begin
        unique case (cnt[1:0])
            2'd0:    hdr_b = ident;
            2'd1:    hdr_b = r_wc[7:0];
            2'd2:    hdr_b = r_wc[15:8];
            default: hdr_b = ecc_b;
        endcase
    end

    // next state and shared index counter
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) st_n = ST_LEAD;
            end
            ST_LEAD: begin
                st_n  = ST_HDR;
                cnt_n = '0;
            end
            ST_HDR: begin
                if (cnt == HDR_LAST) begin
                    cnt_n = '0;
                    if (!r_long) begin
                        st_n = ST_TRL;
                    end else if (r_wc == '0) begin
                        st_n = ST_FTR;
                    end else begin
                        st_n  = ST_PAY;
                        cnt_n = r_wc;
                    end
                end else begin
                    cnt_n = cnt + WC_W'(1);
                end
            end
            ST_PAY: begin
                if (pay_valid) begin
                    if (cnt == WC_W'(1)) begin
                        st_n  = ST_FTR;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt - WC_W'(1);
                    end
                end
            end
            ST_FTR: begin
                if (cnt[0]) begin
                    st_n = ST_TRL;
                end else begin
                    cnt_n = cnt + WC_W'(1);
                end
            end
            ST_TRL: begin
                st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            r_vc   <= '0;
            r_dt   <= '0;
            r_wc   <= '0;
            r_long <= 1'b0;
            last_b <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (st == ST_IDLE && req_valid) begin
                r_vc   <= req_vc;
                r_dt   <= req_dt;
                r_wc   <= req_wc;
                r_long <= req_long;
            end
            if (out_valid) last_b <= out_byte;
        end
    end

    // outputs
    always_comb begin
        req_ready = (st == ST_IDLE);
        out_valid = 1'b0;
        out_sel   = SEL_NONE;
        out_byte  = '0;
        unique case (st)
            ST_IDLE: ;
            ST_LEAD: begin
                out_valid = 1'b1;
                out_sel   = SEL_LEAD;
                out_byte  = SYNC_BYTE;
            end
            ST_HDR: begin
                out_valid = 1'b1;
                out_sel   = SEL_HDR;
                out_byte  = hdr_b;
            end
            ST_PAY: begin
                if (pay_valid) begin
                    out_valid = 1'b1;
                    out_sel   = SEL_PAY;
                    out_byte  = pay_data;
                end
            end
            ST_FTR: begin
                out_valid = 1'b1;
                out_sel   = SEL_FTR;
                out_byte  = cnt[0] ? crc[15:8] : crc[7:0];
            end
            ST_TRL: begin
                out_valid = 1'b1;
                out_sel   = SEL_TRL;
                out_byte  = {BYTE_W{~last_b[BYTE_W-1]}};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/csi_pkt_framer_chk.sv
module csi_pkt_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       pay_valid,
    input logic [7:0] pay_data,
    input logic       out_valid,
    input logic [2:0] out_sel,
    input logic [7:0] out_byte
);

    logic [2:0] hdr_seen;
    logic [7:0] prev_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_seen <= '0;
            prev_b   <= '0;
        end else begin
            hdr_seen <= (out_sel == 3'd2) ? hdr_seen + 3'd1 : 3'd0;
            if (out_valid) prev_b <= out_byte;
        end
    end

    p_lead_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid && out_sel == 3'd1 && out_byte == 8'hB8));

    p_hdr_after_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'd1) |=> (out_sel == 3'd2));

    p_ecc_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'd2 && hdr_seen == 3'd3) |-> (out_byte[7:6] == 2'b00));

    p_hdr_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'd2) |-> (hdr_seen < 3'd4));

    p_pay_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'd3) |-> (pay_valid && out_byte == pay_data));

    p_trail_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'd5) |-> (out_byte == {8{~prev_b[7]}}));

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    p_trail_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'd5) |=> req_ready);

    p_valid_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == (out_sel != 3'd0)) && (out_sel <= 3'd5));

endmodule

bind csi_pkt_framer csi_pkt_framer_chk u_chk (.*);

// File: tb/csi_pkt_framer_test.sv
module csi_pkt_framer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_vc;
    logic [5:0]  req_dt;
    logic [15:0] req_wc;
    logic        req_long;
    logic        pay_valid;
    logic [7:0]  pay_data;
    logic        out_valid;
    logic [2:0]  out_sel;
    logic [7:0]  out_byte;

    int checks = 0;
    int errors = 0;
    logic [7:0] pl [0:63];

    always #4 clk = ~clk;

    csi_pkt_framer uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ecc_ref(input logic [23:0] d);
        logic [7:0] p;
        p = 8'h00;
        p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
        p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
        return p;
    endfunction

    // MSB-first engine on a bit-reversed register, equivalent to LSB-first shifting
    function automatic logic [15:0] crc_ref(input int n);
        logic [15:0] r;
        logic [15:0] o;
        logic        fb;
        r = 16'hFFFF;
        for (int b = 0; b < n; b++) begin
            for (int i = 0; i < 8; i++) begin
                fb = r[15] ^ pl[b][i];
                r  = {r[14:0], 1'b0};
                if (fb) r = r ^ 16'h1021;
            end
        end
        for (int i = 0; i < 16; i++) o[i] = r[15-i];
        return o;
    endfunction

    task automatic run_pkt(input logic [1:0] vc, input logic [5:0] dt, input int wc,
                           input bit lng, input int gap, input bit hi_msb);
        logic [7:0]  hb [0:3];
        logic [15:0] ecrc;
        logic [7:0]  eb;
        logic [2:0]  es;
        logic        ev;
        logic [7:0]  lastb;
        bit          dv;
        int          ph;
        int          idx;
        int          pi;
        int          guard;
        string       tag;
        for (int i = 0; i < wc; i++) begin
            pl[i] = 8'($urandom);
            if (hi_msb) pl[i][7] = 1'b1;
        end
        ecrc  = lng ? crc_ref(wc) : 16'h0;
        hb[0] = {vc, dt};
        hb[1] = 8'(wc);
        hb[2] = 8'(wc >> 8);
        hb[3] = ecc_ref({16'(wc), vc, dt});
        @(negedge clk);
        req_valid = 1'b1;
        req_vc = vc; req_dt = dt; req_wc = 16'(wc); req_long = lng;
        #1;
        chk(req_ready == 1'b1, "R8 ready while idle", 32'(req_ready), 32'h1);
        @(negedge clk);
        ph = 0; idx = 0; pi = 0; guard = 0; lastb = 8'h00;
        while (ph < 5 && guard < 400) begin
            guard++;
            req_valid = 1'b1;
            req_vc = 2'($urandom); req_dt = 6'($urandom);
            req_wc = 16'($urandom); req_long = 1'($urandom);
            dv = (($urandom % 100) >= gap);
            pay_valid = dv;
            pay_data  = (ph == 2 && dv) ? pl[pi] : 8'($urandom);
            #1;
            ev = 1'b1; es = 3'd0; eb = 8'h00; tag = "";
            case (ph)
                0: begin es = 3'd1; eb = 8'hB8; tag = "R1/R10 leader"; end
                1: begin
                    es = 3'd2; eb = hb[idx];
                    tag = (idx == 3) ? "R3 ecc byte" : (lng ? "R2 header" : "R2/R4 header");
                end
                2: begin
                    tag = "R5 payload";
                    if (dv) begin es = 3'd3; eb = pl[pi]; end
                    else ev = 1'b0;
                end
                3: begin
                    es = 3'd4; eb = idx[0] ? ecrc[15:8] : ecrc[7:0];
                    tag = (wc == 0) ? "R6 footer wc0" : "R6 footer";
                end
                default: begin
                    es = 3'd5; eb = {8{~lastb[7]}};
                    tag = lng ? "R7 trail" : "R7/R4 trail";
                end
            endcase
            chk({out_valid, out_sel, out_byte} == {ev, es, eb}, tag,
                32'({out_valid, out_sel, out_byte}), 32'({ev, es, eb}));
            chk(req_ready == 1'b0, "R8 busy not ready", 32'(req_ready), 32'h0);
            if (ev) lastb = eb;
            case (ph)
                0: begin ph = 1; idx = 0; end
                1: begin
                    if (idx == 3) begin
                        idx = 0;
                        ph = !lng ? 4 : (wc == 0 ? 3 : 2);
                    end else idx++;
                end
                2: if (dv) begin
                    pi++;
                    if (pi == wc) begin ph = 3; idx = 0; end
                end
                3: begin
                    if (idx == 1) ph = 4;
                    else idx++;
                end
                default: begin
                    ph = 5;
                    req_valid = 1'b0;
                end
            endcase
            if (ph < 5) @(negedge clk);
        end
        chk(ph == 5, "R5 packet completes", 32'(ph), 32'd5);
        @(negedge clk);
        pay_valid = 1'b1; pay_data = 8'($urandom);
        #1;
        chk(req_ready == 1'b1 && out_valid == 1'b0, "R8 idle after trail, payload ignored",
            32'({req_ready, out_valid}), 32'h2);
        pay_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        rst_n = 1'b0; req_valid = 1'b0; req_vc = '0; req_dt = '0; req_wc = '0;
        req_long = 1'b0; pay_valid = 1'b0; pay_data = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1 && out_valid == 1'b0 && out_sel == 3'd0, "R9 reset state",
            32'({req_ready, out_valid, out_sel}), 32'h10);
        @(negedge clk);
        rst_n = 1'b1;
        // directed corners
        run_pkt(2'd0, 6'h00, 0, 1'b0, 0, 1'b0);      // short, all-zero header
        run_pkt(2'd3, 6'h01, 16'hBEEF, 1'b0, 50, 1'b0); // short, payload inputs busy
        run_pkt(2'd1, 6'h1E, 0, 1'b1, 0, 1'b0);      // long, empty payload, CRC seed
        run_pkt(2'd2, 6'h1E, 1, 1'b1, 0, 1'b1);      // long, one byte
        run_pkt(2'd0, 6'h2A, 8, 1'b1, 0, 1'b1);      // no gaps, high MSB data
        run_pkt(2'd3, 6'h3F, 33, 1'b1, 60, 1'b0);    // many gaps
        for (int n = 0; n < 40; n++) begin
            run_pkt(2'($urandom), 6'($urandom), int'($urandom % 64),
                    1'($urandom), int'($urandom % 60), 1'($urandom));
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule